// File: doc/BRIEF.md
# Packet Data Port with Auto-Advancing Offset

This block gives a host processor byte- and word-wide access to a packet buffer through two registers. The first is a 16-bit pointer word. It chooses the packet, sets the direction of the coming transfers and gives the byte offset inside that packet. The second is a data port that is read or written one byte or one 16-bit word at a time. With auto-advance enabled, the offset moves past each accepted access, so a driver can stream a whole frame through the data port without rewriting the pointer.

A packet is chosen by one of two packet numbers that arrive on input pins: the head of the receive queue, or the number the host has placed for transmit. The pointer write selects which one to use and latches its value. The buffer keeps frames in a fixed layout:
- a 16-bit status word at offset 0;
- an 11-bit byte count at offset 2;
- the destination address from offset 4 and the source address from offset 10;
- payload from offset 16;
- a trailing word whose upper byte is a control byte, with bit 5 flagging an odd length and bit 4 asking for a CRC on transmit.

The port itself treats all of these as plain bytes. The buffer is an internal array. Packet allocation and the bus bridge sit outside the block.

When the pointer is written in read direction, the first word is fetched at once. The first host read can therefore be issued in the very next cycle, and back-to-back reads need no wait states.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer reads back as 0x0000 and the data port returns 0x0000.
- R2: Pointer word fields are: bit 15 = packet source, bit 14 = auto-advance enable, bit 13 = read direction, bits OFF_W-1:0 = byte offset. Bits 12 down to OFF_W read back as zero. `ptr_rdata` returns the stored fields one cycle after the write.
- R3: On a pointer write, a source bit of 1 latches `rx_head_pkt` and a source bit of 0 latches `tx_pkt_num`. Later changes on those inputs have no effect until the next pointer write.
- R4: Byte accesses use the byte at the current offset. An even offset is bits 7:0 of the stored word and an odd offset is bits 15:8. A byte write takes `dat_wdata[7:0]` and leaves the other byte of the word unchanged. A byte read returns the byte in bits 7:0 with bits 15:8 zero.
- R5: Word accesses (`dat_word`=1) address the word that holds the current offset, with offset bit 0 ignored. The byte at the even address is bits 7:0.
- R6: With auto-advance set, each accepted access adds 1 (byte) or 2 (word) to the offset, modulo 2^OFF_W. With auto-advance clear, the offset holds.
- R7: A read in the cycle right after a read-direction pointer write returns valid data, and reads in consecutive cycles each return the data at their own offset.
- R8: In read direction, data writes change neither the buffer nor the offset. In write direction, data reads return 0x0000 and do not move the offset.
- R9: A pointer write in the same cycle as a data access wins. The data access is dropped and the buffer is left unchanged.
- R10: Writes to one packet do not alter the contents of any other packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 1 | Pointer word write strobe |
| ptr_wdata | input | 16 | Pointer word written by the host |
| ptr_rdata | output | 16 | Current pointer word (fields, offset) |
| rx_head_pkt | input | PKT_W | Packet number at the receive-queue head |
| tx_pkt_num | input | PKT_W | Host-placed transmit packet number |
| dat_rd | input | 1 | Data port read strobe |
| dat_we | input | 1 | Data port write strobe |
| dat_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| dat_wdata | input | 16 | Write data (byte access uses bits 7:0) |
| dat_rdata | output | 16 | Read data, valid in the cycle of the read strobe |

## Verification
A pointer write is visible on `ptr_rdata` one cycle later. The fetched word for a read-direction pointer is ready in that same next cycle. Read data is combinational from the stored word and the current offset, so the bench samples `dat_rdata` 1 ns after the negative edge at which it raised `dat_rd`, before the accepting edge. Offset moves and buffer writes take effect at the accepting edge, so the bench compares `ptr_rdata` 1 ns after that edge, against an offset it advances itself by the access width. The sweeps fill every byte of every packet with mixed byte and word writes, then read each packet back in both widths, with odd starting offsets and across the wrap boundary.

// File: rtl/pdp_pkg.sv
// Package: shared field positions and the stored pointer mode type for the
// packet data port. Assumes a 16-bit pointer word and a 16-bit data port.
package pdp_pkg;
    localparam int PTR_W       = 16;
    localparam int SRC_BIT     = 15;  // 1 = receive head, 0 = transmit number
    localparam int AINC_BIT    = 14;  // auto-advance enable
    localparam int RDIR_BIT    = 13;  // read direction
    localparam int MAX_OFF_W   = 12;  // offset must sit below the mode bits

    typedef struct packed {
        logic src_rx;
        logic autoinc;
        logic rd_mode;
    } ptr_mode_t;
endpackage

// File: rtl/pdp_ptr_ctrl.sv
// Module: pointer register and offset sequencer.
// Holds the mode bits, the byte offset and the latched packet number, and
// computes their next values so the buffer can fetch ahead of the host.
// Assumes OFF_W <= 12 and that a pointer write overrides any data access.
module pdp_ptr_ctrl
    import pdp_pkg::*;
#(
    parameter int OFF_W = 11,
    parameter int PKT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic [PKT_W-1:0] rx_head_pkt,
    input  logic [PKT_W-1:0] tx_pkt_num,
    input  logic             dat_rd,
    input  logic             dat_we,
    input  logic             dat_word,
    output ptr_mode_t        mode_q,
    output logic [OFF_W-1:0] off_q,
    output logic [PKT_W-1:0] pkt_q,
    output ptr_mode_t        mode_nxt,
    output logic [OFF_W-1:0] off_nxt,
    output logic [PKT_W-1:0] pkt_nxt,
    output logic             acc_wr
);
    logic             acc_rd;
    logic [OFF_W-1:0] step;
    logic             unused_rsvd;

    // Reserved pointer bits are accepted and discarded.
    assign unused_rsvd = ^ptr_wdata[MAX_OFF_W:OFF_W];

    // Decide which data strobes are accepted in the present direction.
    always_comb begin
        acc_rd = dat_rd && mode_q.rd_mode && !ptr_we;
        acc_wr = dat_we && !mode_q.rd_mode && !ptr_we;
        step   = dat_word ? OFF_W'(2) : OFF_W'(1);
    end

    // Next pointer state: a pointer write loads, an accepted access advances.
    always_comb begin
        mode_nxt = mode_q;
        off_nxt  = off_q;
        pkt_nxt  = pkt_q;
        if (ptr_we) begin
            mode_nxt.src_rx  = ptr_wdata[SRC_BIT];
            mode_nxt.autoinc = ptr_wdata[AINC_BIT];
            mode_nxt.rd_mode = ptr_wdata[RDIR_BIT];
            off_nxt          = ptr_wdata[OFF_W-1:0];
            pkt_nxt          = ptr_wdata[SRC_BIT] ? rx_head_pkt : tx_pkt_num;
        end else if ((acc_rd || acc_wr) && mode_q.autoinc) begin
            off_nxt = off_q + step;
        end
    end

    // Pointer state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            off_q  <= '0;
            pkt_q  <= '0;
        end else begin
            mode_q <= mode_nxt;
            off_q  <= off_nxt;
            pkt_q  <= pkt_nxt;
        end
    end

    // R2: a pointer write lands in the stored fields one cycle later.
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (off_q == $past(ptr_wdata[OFF_W-1:0]))
                   && (mode_q.rd_mode == $past(ptr_wdata[RDIR_BIT])));

    // R3: the latched packet number only changes on a pointer write.
    a_r3_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> (pkt_q == $past(pkt_q)));

    // R6: without auto-advance the offset holds.
    a_r6_no_ainc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && !mode_q.autoinc) |=> $stable(off_q));

    // R6: an accepted read advances by the access width.
    a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && mode_q.autoinc && mode_q.rd_mode && dat_rd)
        |=> (off_q == OFF_W'($past(off_q) + ($past(dat_word) ? 2 : 1))));

    // R8: in read direction a lone write strobe does not move the offset.
    a_r8_rmode_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && mode_q.rd_mode && !dat_rd) |=> $stable(off_q));

    // R8: in write direction a lone read strobe does not move the offset.
    a_r8_wmode_rd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && !mode_q.rd_mode && !dat_we) |=> $stable(off_q));
endmodule

// File: rtl/pdp_pkt_ram.sv
// Module: packet buffer, one byte-wide array per lane of a 16-bit word.
// Writes are byte-enabled; the read port is registered and loads only when
// enabled. Assumes the caller never reads and writes in the same cycle,
// so no bypass is provided. The arrays carry no reset.
module pdp_pkt_ram #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_word
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int LANES = 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_lane;

        // Per-lane write and registered fetch.
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                mem[wr_idx] <= wr_data[g*8 +: 8];
            end
            if (rd_en) begin
                rd_lane <= mem[rd_idx];
            end
        end

        assign rd_word[g*8 +: 8] = rd_lane;
    end
endmodule

// File: rtl/pdp_lane_sel.sv
// Module: read data formatter. Picks the whole fetched word or one byte of
// it by offset bit 0, and forces zero while the pointer is in write
// direction. Purely combinational.
module pdp_lane_sel (
    input  logic        rd_mode,
    input  logic        dat_word,
    input  logic        byte_hi,
    input  logic [15:0] fetched,
    output logic [15:0] dat_rdata
);
    // Shape the fetched word into the host's read value.
    always_comb begin
        if (!rd_mode) begin
            dat_rdata = '0;
        end else if (dat_word) begin
            dat_rdata = fetched;
        end else begin
            dat_rdata = {8'h00, byte_hi ? fetched[15:8] : fetched[7:0]};
        end
    end
endmodule

// File: rtl/pkt_data_port.sv
// Module: top of the packet data port. Joins the pointer sequencer, the
// packet buffer and the read formatter. The buffer is fetched at the
// next pointer state every cycle the port is in read direction, so data
// is waiting before the host asks. Assumes NUM_PKTS is a power of two.
module pkt_data_port
    import pdp_pkg::*;
#(
    parameter int OFF_W    = 11,
    parameter int NUM_PKTS = 2,
    localparam int PKT_W   = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic [15:0]      ptr_wdata,
    output logic [15:0]      ptr_rdata,
    input  logic [PKT_W-1:0] rx_head_pkt,
    input  logic [PKT_W-1:0] tx_pkt_num,
    input  logic             dat_rd,
    input  logic             dat_we,
    input  logic             dat_word,
    input  logic [15:0]      dat_wdata,
    output logic [15:0]      dat_rdata
);
    localparam int IDX_W = PKT_W + OFF_W - 1;

    ptr_mode_t        mode_q, mode_nxt;
    logic [OFF_W-1:0] off_q, off_nxt;
    logic [PKT_W-1:0] pkt_q, pkt_nxt;
    logic             acc_wr;
    logic [1:0]       wr_be;
    logic [15:0]      wr_data;
    logic [15:0]      fetched;

    pdp_ptr_ctrl #(.OFF_W(OFF_W), .PKT_W(PKT_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_we      (ptr_we),
        .ptr_wdata   (ptr_wdata),
        .rx_head_pkt (rx_head_pkt),
        .tx_pkt_num  (tx_pkt_num),
        .dat_rd      (dat_rd),
        .dat_we      (dat_we),
        .dat_word    (dat_word),
        .mode_q      (mode_q),
        .off_q       (off_q),
        .pkt_q       (pkt_q),
        .mode_nxt    (mode_nxt),
        .off_nxt     (off_nxt),
        .pkt_nxt     (pkt_nxt),
        .acc_wr      (acc_wr)
    );

    // Lane enables and lane-replicated data for a buffer write.
    always_comb begin
        if (dat_word) begin
            wr_be   = 2'b11;
            wr_data = dat_wdata;
        end else begin
            wr_be   = off_q[0] ? 2'b10 : 2'b01;
            wr_data = {dat_wdata[7:0], dat_wdata[7:0]};
        end
    end

    pdp_pkt_ram #(.IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .wr_en   (acc_wr),
        .wr_idx  ({pkt_q, off_q[OFF_W-1:1]}),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_en   (mode_nxt.rd_mode),
        .rd_idx  ({pkt_nxt, off_nxt[OFF_W-1:1]}),
        .rd_word (fetched)
    );

    pdp_lane_sel u_lane (
        .rd_mode   (mode_q.rd_mode),
        .dat_word  (dat_word),
        .byte_hi   (off_q[0]),
        .fetched   (fetched),
        .dat_rdata (dat_rdata)
    );

    // Pointer readback: mode bits on top, offset at the bottom, rest zero.
    always_comb begin
        ptr_rdata              = '0;
        ptr_rdata[SRC_BIT]     = mode_q.src_rx;
        ptr_rdata[AINC_BIT]    = mode_q.autoinc;
        ptr_rdata[RDIR_BIT]    = mode_q.rd_mode;
        ptr_rdata[OFF_W-1:0]   = off_q;
    end

    // R8: write direction always reads as zero at the port.
    a_r8_wmode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !ptr_rdata[RDIR_BIT]) |-> (dat_rdata == 16'h0000));

    // R4: a byte read never drives the upper half.
    a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !dat_word) |-> (dat_rdata[15:8] == 8'h00));
endmodule

// File: tb/pkt_data_port_tb.sv
`timescale 1ns/1ps
module pkt_data_port_tb;
    localparam int OFF_W = 6;
    localparam int NP    = 4;
    localparam int PW    = 2;
    localparam int PB    = 1 << OFF_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_we = 1'b0;
    logic [15:0]   ptr_wdata = '0;
    logic [15:0]   ptr_rdata;
    logic [PW-1:0] rx_head_pkt = '0;
    logic [PW-1:0] tx_pkt_num = '0;
    logic          dat_rd = 1'b0;
    logic          dat_we = 1'b0;
    logic          dat_word = 1'b0;
    logic [15:0]   dat_wdata = '0;
    logic [15:0]   dat_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [NP][PB];
    int e_off, e_pkt;
    bit e_src, e_ai, e_rd;

    always #2.5 clk = ~clk;

    pkt_data_port #(.OFF_W(OFF_W), .NUM_PKTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .ptr_rdata(ptr_rdata), .rx_head_pkt(rx_head_pkt),
        .tx_pkt_num(tx_pkt_num), .dat_rd(dat_rd), .dat_we(dat_we),
        .dat_word(dat_word), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_word(bit s, bit a, bit r, int off);
        return {s, a, r, 13'(off % PB)};
    endfunction

    task automatic chk_ptr(string req);
        check(req, ptr_rdata, ptr_word(e_src, e_ai, e_rd, e_off));
    endtask

    // Pointer write; the bench latches its own expectation of the packet.
    task automatic do_ptr(bit s, bit a, bit r, int off);
        @(negedge clk);
        ptr_we = 1'b1;
        ptr_wdata = ptr_word(s, a, r, off);
        e_pkt = s ? int'(rx_head_pkt) : int'(tx_pkt_num);
        @(posedge clk);
        #1 ptr_we = 1'b0;
        e_src = s; e_ai = a; e_rd = r; e_off = off % PB;
    endtask

    task automatic wr_acc(bit w, logic [15:0] v);
        @(negedge clk);
        dat_we = 1'b1; dat_word = w; dat_wdata = v;
        @(posedge clk);
        #1 dat_we = 1'b0;
        if (!e_rd) begin
            if (w) begin
                model[e_pkt][e_off & ~1] = v[7:0];
                model[e_pkt][e_off | 1]  = v[15:8];
            end else begin
                model[e_pkt][e_off] = v[7:0];
            end
            if (e_ai) e_off = (e_off + (w ? 2 : 1)) % PB;
        end
    endtask

    task automatic rd_acc(bit w, string req);
        logic [15:0] exp;
        @(negedge clk);
        dat_rd = 1'b1; dat_word = w;
        #1;
        if (!e_rd) exp = 16'h0000;
        else if (w) exp = {model[e_pkt][e_off | 1], model[e_pkt][e_off & ~1]};
        else exp = {8'h00, model[e_pkt][e_off]};
        check(req, dat_rdata, exp);
        @(posedge clk);
        #1 dat_rd = 1'b0;
        if (e_rd && e_ai) e_off = (e_off + (w ? 2 : 1)) % PB;
    endtask

    initial begin
        e_off = 0; e_pkt = 0; e_src = 0; e_ai = 0; e_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 pointer after reset", ptr_rdata, 16'h0000);
        check("R1 data after reset", dat_rdata, 16'h0000);

        // R2: reserved bits dropped, fields read back.
        do_ptr(1'b1, 1'b0, 1'b1, 45);
        chk_ptr("R2 readback");
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = 16'h5FC3; e_pkt = int'(tx_pkt_num);
        @(posedge clk);
        #1 ptr_we = 1'b0;
        e_src = 0; e_ai = 1; e_rd = 0; e_off = 16'h5FC3 & (PB - 1);
        check("R2 reserved bits zero", ptr_rdata, 16'h4003);

        // R4 R5 R6 R10: fill every packet with mixed byte/word writes.
        for (int p = 0; p < NP; p++) begin
            tx_pkt_num = PW'(p);
            rx_head_pkt = PW'((p + 1) % NP);
            do_ptr(1'b0, 1'b1, 1'b0, 0);
            for (int i = 0; i < PB; ) begin
                if (i % 4 == 0) begin
                    wr_acc(1'b1, {8'((p * 37 + (i + 1) * 11 + 5)),
                                  8'((p * 37 + i * 11 + 5))});
                    i += 2;
                end else begin
                    wr_acc(1'b0, {8'hEE, 8'((p * 37 + i * 11 + 5))});
                    i += 1;
                end
            end
            chk_ptr("R6 offset wrapped after fill");
        end

        // R3 R5 R7 R10: read every packet back as words, receive source.
        for (int p = 0; p < NP; p++) begin
            rx_head_pkt = PW'(p);
            tx_pkt_num = PW'((p + 2) % NP);
            do_ptr(1'b1, 1'b1, 1'b1, 0);
            for (int k = 0; k < PB / 2; k++) rd_acc(1'b1, "R7 R10 word stream");
            chk_ptr("R6 offset after word stream");
        end

        // R4: byte stream from an odd start.
        rx_head_pkt = 2'd1;
        do_ptr(1'b1, 1'b1, 1'b1, 33);
        for (int k = 0; k < PB; k++) begin
            rd_acc(1'b0, "R4 byte stream");
            chk_ptr("R6 byte step");
        end

        // R3 R6: latched packet holds, no auto-advance keeps offset.
        rx_head_pkt = 2'd2;
        do_ptr(1'b1, 1'b0, 1'b1, 10);
        rx_head_pkt = 2'd3;
        rd_acc(1'b1, "R3 latched packet");
        rd_acc(1'b0, "R3 latched packet byte");
        chk_ptr("R6 no advance");

        // R5: word write at odd offset covers bytes 4..5.
        tx_pkt_num = 2'd1;
        do_ptr(1'b0, 1'b1, 1'b0, 5);
        wr_acc(1'b1, 16'hBEEF);
        chk_ptr("R5 R6 odd word step");
        do_ptr(1'b0, 1'b0, 1'b1, 4);
        rd_acc(1'b1, "R5 odd word placement");
        check("R5 explicit value", {model[1][5], model[1][4]}, 16'hBEEF);

        // R4: byte write leaves neighbour intact.
        do_ptr(1'b0, 1'b0, 1'b0, 9);
        wr_acc(1'b0, 16'h77A5);
        do_ptr(1'b0, 1'b0, 1'b1, 8);
        rd_acc(1'b1, "R4 byte write lane");

        // R6: wrap at the top.
        do_ptr(1'b0, 1'b1, 1'b1, PB - 2);
        rd_acc(1'b1, "R6 word at top");
        chk_ptr("R6 word wrap");
        do_ptr(1'b0, 1'b1, 1'b1, PB - 1);
        rd_acc(1'b1, "R6 word at last odd");
        chk_ptr("R6 odd word wrap");

        // R8: writes ignored in read direction, reads zero in write direction.
        do_ptr(1'b0, 1'b1, 1'b1, 20);
        wr_acc(1'b1, 16'h1234);
        chk_ptr("R8 write ignored offset");
        rd_acc(1'b1, "R8 buffer unchanged");
        do_ptr(1'b0, 1'b1, 1'b0, 20);
        rd_acc(1'b1, "R8 write-direction read");
        chk_ptr("R8 read ignored offset");

        // R9: pointer write beats a same-cycle data write.
        do_ptr(1'b0, 1'b1, 1'b0, 30);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = ptr_word(1'b0, 1'b1, 1'b0, 40);
        dat_we = 1'b1; dat_word = 1'b1; dat_wdata = 16'hAAAA;
        e_pkt = int'(tx_pkt_num);
        @(posedge clk);
        #1 ptr_we = 1'b0; dat_we = 1'b0;
        e_off = 40;
        chk_ptr("R9 pointer wins");
        do_ptr(1'b0, 1'b0, 1'b1, 30);
        rd_acc(1'b1, "R9 data dropped");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule